// File: doc/BRIEF.md
# Multi-Mode Pixel Unpacker with Palette Page Addressing

The block sits between a frame buffer port and a colour look-up table. Once per word period it latches a pixel word from the bus and then issues one 8-bit palette address per dot clock until every pixel in that word has gone out. Pixels may be 1, 2, 4 or 8 bits wide. The bus may be 4, 8, 16 or 32 bits wide, so the number of dot clocks per word is the bus width divided by the pixel width. Pixel bits form the low end of each address. A page value fills the address bits above the pixel, so one small pixel can index any group of colours in the table.

A nibble mode overrides the width selects. It takes a 32-bit word as four bytes and keeps either the low or the high nibble of each byte, as a flag chooses. The result is four 4-bit pixels. The order in which pixels leave a word can be set to least-significant-first or most-significant-first. A width combination that cannot work is reported on an error output, and while it lasts the block issues no load and no address.

Top module: `pix_unpack`

## Requirements
- R1: In 1-, 2- and 4-bit modes (bpp_sel_i = 0, 1, 2), bits [b-1:0] of pal_addr_o hold the pixel and bits [7:b] equal page_i[7:b], where b is the pixel width.
- R2: In 8-bit mode (bpp_sel_i = 3), pal_addr_o is the 8 pixel bits and does not depend on page_i.
- R3: load_o is high in the cycle that precedes each word. pix_word_i is sampled at the rising edge where load_o is high. Pixel 0 of that word appears in the next cycle, and load_o rises again in the cycle that shows the last pixel. The ratio is bus/bpp, with bus_sel_i 0..3 giving 4, 8, 16 or 32 bits.
- R4: With big_endian_i = 0, the first pixel after a load is taken from bits [b-1:0], and later pixels move toward the MSB.
- R5: With big_endian_i = 1, the first pixel after a load is taken from the most significant valid bits of the bus, and later pixels move toward the LSB.
- R6: Bits of pix_word_i at or above the selected bus width have no effect.
- R7: Nibble mode is active when nib_en_i = 1 and nib_inhibit_i = 0, and it ignores bpp_sel_i and bus_sel_i. Nibble i of the pixel data is bits [8i+3:8i] of the word when nib_flag_i = 0, and bits [8i+7:8i+4] when nib_flag_i = 1. This gives 4 pixels of 4 bits with page_i[7:4] on top.
- R8: With nib_en_i = 1 and nib_inhibit_i = 1, the block works in the mode set by bpp_sel_i and bus_sel_i.
- R9: A 4-bit bus with 8-bit pixels, outside nibble mode, sets cfg_err_o. While cfg_err_o is high, load_o, pal_valid_o and pal_addr_o are 0. Once the error clears, load_o is 1 at once.
- R10: While in reset, pal_valid_o and pal_addr_o are 0 and load_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_word_i | input | 32 | Pixel word; valid bits at the LSB end |
| bpp_sel_i | input | 2 | Pixel width: 0=1, 1=2, 2=4, 3=8 bits |
| bus_sel_i | input | 2 | Bus width: 0=4, 1=8, 2=16, 3=32 bits |
| big_endian_i | input | 1 | 1: most significant pixel goes out first |
| nib_en_i | input | 1 | Nibble mode request |
| nib_inhibit_i | input | 1 | Blocks the nibble mode request when 1 |
| nib_flag_i | input | 1 | Nibble mode: 0 low nibble, 1 high nibble |
| page_i | input | 8 | Page bits for the upper address |
| load_o | output | 1 | Word is taken at this rising edge |
| pal_valid_o | output | 1 | pal_addr_o carries a pixel |
| pal_addr_o | output | 8 | Palette address |
| cfg_err_o | output | 1 | Illegal width combination |

## Verification
Ratios from 1:1 up to 32:1 are exercised:
- 32:1 with 1-bit pixels on a 32-bit bus.
- 8:1 with 2-bit pixels on a 16-bit bus.
- 2:1 with 4-bit pixels on an 8-bit bus.
- 4:1 with 8-bit pixels on a 32-bit bus.
- 1:1 with 4-bit pixels on a 4-bit bus.

Because each ratio puts the load strobe in a different cycle, these cases show whether the word counter and the pixel index shift are right. Pixel words are pseudo-random. Each width runs in both orders, which separates a reversed index from a correct one. Garbage above the bus width exposes a missing mask.

The 8-bit mode runs with two very different page values, so a page leaking into the address is caught. The nibble cases run with both flag values, and also with width selects that would be illegal if the mode were not overridden. The inhibited nibble request must give normal-mode results. The illegal configuration is checked both from reset and mid-stream, and recovery is checked after it clears.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  typedef enum logic [1:0] {BPP_1 = 2'd0, BPP_2 = 2'd1, BPP_4 = 2'd2, BPP_8 = 2'd3} bpp_e;
  typedef enum logic [1:0] {BUS_4 = 2'd0, BUS_8 = 2'd1, BUS_16 = 2'd2, BUS_32 = 2'd3} bus_e;

  // log2 encoded effective configuration
  typedef struct packed {
    logic [2:0] bpp_lg;
    logic [2:0] bus_lg;
    logic [2:0] ratio_lg;
    logic       nibble;
    logic       err;
  } cfg_t;
endpackage

// File: rtl/pix_cfg_decode.sv
module pix_cfg_decode
  import pix_unpack_pkg::*;
(
  input  logic [1:0] bpp_sel_i,
  input  logic [1:0] bus_sel_i,
  input  logic       nib_en_i,
  input  logic       nib_inhibit_i,
  output cfg_t       cfg_o
);
  bpp_e bpp;
  bus_e bus;

  always_comb begin
    bpp = bpp_e'(bpp_sel_i);
    bus = bus_e'(bus_sel_i);
    cfg_o.nibble = nib_en_i & ~nib_inhibit_i;
    case (bpp)
      BPP_1:   cfg_o.bpp_lg = 3'd0;
      BPP_2:   cfg_o.bpp_lg = 3'd1;
      BPP_4:   cfg_o.bpp_lg = 3'd2;
      default: cfg_o.bpp_lg = 3'd3;
    endcase
    case (bus)
      BUS_4:   cfg_o.bus_lg = 3'd2;
      BUS_8:   cfg_o.bus_lg = 3'd3;
      BUS_16:  cfg_o.bus_lg = 3'd4;
      default: cfg_o.bus_lg = 3'd5;
    endcase
    if (cfg_o.nibble) begin
      // four 4-bit pixels out of a compacted 16-bit word
      cfg_o.bpp_lg = 3'd2;
      cfg_o.bus_lg = 3'd4;
    end
    cfg_o.err      = cfg_o.bus_lg < cfg_o.bpp_lg;
    cfg_o.ratio_lg = cfg_o.err ? 3'd0 : cfg_o.bus_lg - cfg_o.bpp_lg;
  end
endmodule

// File: rtl/pix_word_shifter.sv
module pix_word_shifter
  import pix_unpack_pkg::*;
#(
  parameter int PIX_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cfg_t              cfg_i,
  input  logic              big_endian_i,
  input  logic              nib_flag_i,
  input  logic [PIX_W-1:0]  word_i,
  output logic              load_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] pix_o
);
  localparam int IDX_W  = $clog2(PIX_W);
  localparam int CNT_W  = IDX_W + 1;
  localparam int NBYTES = PIX_W / 8;

  logic [PIX_W-1:0] nib_word, bus_mask, packed_word, word_q, shifted;
  logic [IDX_W-1:0] idx_q, ratio_m1, pidx, shamt;
  logic [CNT_W-1:0] ratio_full;
  logic             valid_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_nib
    assign nib_word[4*b +: 4] = nib_flag_i ? word_i[8*b+4 +: 4] : word_i[8*b +: 4];
  end
  assign nib_word[PIX_W-1:PIX_W/2] = '0;

  always_comb begin
    for (int i = 0; i < PIX_W; i++) begin
      bus_mask[i] = unsigned'(i) < (32'd1 << cfg_i.bus_lg);
    end
  end

  assign packed_word = cfg_i.nibble ? nib_word : (word_i & bus_mask);
  assign ratio_full  = CNT_W'(1) << cfg_i.ratio_lg;
  assign ratio_m1    = IDX_W'(ratio_full - CNT_W'(1));
  assign load_o      = ~cfg_i.err & (~valid_q | (idx_q >= ratio_m1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (cfg_i.err) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_o) begin
      word_q  <= packed_word;
      idx_q   <= '0;
      valid_q <= 1'b1;
    end else begin
      idx_q   <= idx_q + 1'b1;
    end
  end

  assign pidx    = big_endian_i ? (ratio_m1 - idx_q) : idx_q;
  assign shamt   = pidx << cfg_i.bpp_lg;
  assign shifted = word_q >> shamt;
  assign pix_o   = shifted[ADDR_W-1:0];
  assign valid_o = valid_q;

  // R3: a load always leaves a word on display in the next cycle
  a_r3_load_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> valid_q);

  // R3: between loads the pixel index advances by one
  a_r3_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !load_o && !cfg_i.err) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/pix_addr_merge.sv
module pix_addr_merge #(
  parameter int ADDR_W = 8
) (
  input  logic [2:0]        bpp_lg_i,
  input  logic [ADDR_W-1:0] pix_i,
  input  logic [ADDR_W-1:0] page_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int SEL_W = $clog2(ADDR_W) + 1;

  logic [SEL_W-1:0] pix_bits;
  assign pix_bits = SEL_W'(1) << bpp_lg_i;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    localparam logic [SEL_W-1:0] BIT_POS = SEL_W'(i);
    assign addr_o[i] = (BIT_POS < pix_bits) ? pix_i[i] : page_i[i];
  end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter int PIX_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  pix_word_i,
  input  logic [1:0]        bpp_sel_i,
  input  logic [1:0]        bus_sel_i,
  input  logic              big_endian_i,
  input  logic              nib_en_i,
  input  logic              nib_inhibit_i,
  input  logic              nib_flag_i,
  input  logic [ADDR_W-1:0] page_i,
  output logic              load_o,
  output logic              pal_valid_o,
  output logic [ADDR_W-1:0] pal_addr_o,
  output logic              cfg_err_o
);
  cfg_t              cfg;
  logic              shf_valid;
  logic [ADDR_W-1:0] shf_pix, merged;

  pix_cfg_decode u_dec (
    .bpp_sel_i     (bpp_sel_i),
    .bus_sel_i     (bus_sel_i),
    .nib_en_i      (nib_en_i),
    .nib_inhibit_i (nib_inhibit_i),
    .cfg_o         (cfg)
  );

  pix_word_shifter #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_shf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg),
    .big_endian_i (big_endian_i),
    .nib_flag_i   (nib_flag_i),
    .word_i       (pix_word_i),
    .load_o       (load_o),
    .valid_o      (shf_valid),
    .pix_o        (shf_pix)
  );

  pix_addr_merge #(.ADDR_W(ADDR_W)) u_mrg (
    .bpp_lg_i (cfg.bpp_lg),
    .pix_i    (shf_pix),
    .page_i   (page_i),
    .addr_o   (merged)
  );

  assign cfg_err_o   = cfg.err;
  assign pal_valid_o = shf_valid & ~cfg.err;
  assign pal_addr_o  = pal_valid_o ? merged : '0;

  // R9: illegal setup keeps every output quiet
  a_r9_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!load_o && !pal_valid_o && pal_addr_o == '0));

  // R1: single-bit pixels carry seven page bits
  a_r1_page_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pal_valid_o && !cfg.nibble && bpp_sel_i == 2'd0) |->
      (pal_addr_o[ADDR_W-1:1] == page_i[ADDR_W-1:1]));

  // R7: nibble pixels use the 4-bit page split
  a_r7_nib_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pal_valid_o && nib_en_i && !nib_inhibit_i) |->
      (pal_addr_o[ADDR_W-1:4] == page_i[ADDR_W-1:4]));
endmodule

// File: tb/pix_unpack_tb_top.sv
module pix_unpack_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pix_word_i = '0;
  logic [1:0]  bpp_sel_i = '0;
  logic [1:0]  bus_sel_i = '0;
  logic        big_endian_i = 1'b0;
  logic        nib_en_i = 1'b0;
  logic        nib_inhibit_i = 1'b0;
  logic        nib_flag_i = 1'b0;
  logic [7:0]  page_i = '0;
  logic        load_o, pal_valid_o, cfg_err_o;
  logic [7:0]  pal_addr_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pix_unpack dut_i (
    .clk_i, .rst_ni, .pix_word_i, .bpp_sel_i, .bus_sel_i, .big_endian_i,
    .nib_en_i, .nib_inhibit_i, .nib_flag_i, .page_i,
    .load_o, .pal_valid_o, .pal_addr_o, .cfg_err_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ratio_of(int bpp, int bus, bit nib);
    if (nib) return 4;
    return (4 << bus) / (1 << bpp);
  endfunction

  function automatic logic [7:0] exp_addr(logic [31:0] w, int bpp, int bus, bit big,
                                          bit nib, bit flag, logic [7:0] page, int k);
    int b, n, bb, j;
    logic [31:0] d, pix;
    if (nib) begin
      d = '0;
      for (int i = 0; i < 4; i++)
        d |= ((flag ? (w >> (8*i + 4)) : (w >> (8*i))) & 32'hF) << (4*i);
      b = 4;
      n = 4;
    end else begin
      b  = 1 << bpp;
      bb = 4 << bus;
      d  = (bb == 32) ? w : (w & ((32'd1 << bb) - 1));
      n  = bb / b;
    end
    j   = big ? (n - 1 - k) : k;
    pix = (d >> (j * b)) & ((32'd1 << b) - 1);
    if (b == 8) return pix[7:0];
    return (page & ~8'((32'd1 << b) - 1)) | pix[7:0];
  endfunction

  task automatic apply_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R10 valid in reset", {31'b0, pal_valid_o}, 32'd0);
    check("R10 addr in reset", {24'b0, pal_addr_o}, 32'd0);
    check("R10 load in reset", {31'b0, load_o}, {31'b0, ~cfg_err_o});
    rst_ni = 1'b1;
  endtask

  task automatic run_case(string req, int bpp, int bus, bit big, bit nen, bit ninh,
                          bit flag, logic [7:0] page, int nw, logic [31:0] seed);
    bit nib;
    int n;
    logic [31:0] w;
    nib = nen & ~ninh;
    bpp_sel_i = 2'(bpp);
    bus_sel_i = 2'(bus);
    big_endian_i = big;
    nib_en_i = nen;
    nib_inhibit_i = ninh;
    nib_flag_i = flag;
    page_i = page;
    apply_reset();
    n = ratio_of(bpp, bus, nib);
    for (int wi = 0; wi < nw; wi++) begin
      w = seed ^ (32'(wi) * 32'h9E37_79B9);
      check({req, " R3 load at boundary"}, {31'b0, load_o}, 32'd1);
      pix_word_i = w;
      for (int k = 0; k < n; k++) begin
        @(negedge clk_i);
        if (k == 0) pix_word_i = ~w;
        check({req, " valid"}, {31'b0, pal_valid_o}, 32'd1);
        check(req, {24'b0, pal_addr_o}, {24'b0, exp_addr(w, bpp, bus, big, nib, flag, page, k)});
        if (k != n - 1) check({req, " R3 no load mid-word"}, {31'b0, load_o}, 32'd0);
      end
    end
  endtask

  task automatic test_r9_error();
    bpp_sel_i = 2'd3; bus_sel_i = 2'd0; nib_en_i = 1'b0; nib_inhibit_i = 1'b0;
    apply_reset();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk_i);
      check("R9 err flag", {31'b0, cfg_err_o}, 32'd1);
      check("R9 no load", {31'b0, load_o}, 32'd0);
      check("R9 addr zero", {24'b0, pal_addr_o}, 32'd0);
      check("R9 valid zero", {31'b0, pal_valid_o}, 32'd0);
    end
    bus_sel_i = 2'd3;
    #1;
    check("R9 recovery load", {31'b0, load_o}, 32'd1);
    check("R9 err clear", {31'b0, cfg_err_o}, 32'd0);
    pix_word_i = 32'hA5A5_5A5A;
    @(negedge clk_i);
    check("R9 mid-run valid", {31'b0, pal_valid_o}, 32'd1);
    bus_sel_i = 2'd0;
    #1;
    check("R9 mid-run err quiet", {24'b0, pal_addr_o}, 32'd0);
    check("R9 mid-run no load", {31'b0, load_o}, 32'd0);
    @(negedge clk_i);
    check("R9 still quiet", {31'b0, pal_valid_o}, 32'd0);
    bus_sel_i = 2'd3;
    #1;
    check("R9 recovery after mid-run", {31'b0, load_o}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    run_case("R1 R4 1bpp bus32 LE", 0, 3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 3, 32'h1234_5678);
    run_case("R1 R5 1bpp bus32 BE", 0, 3, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3, 2, 32'hF0E1_D2C3);
    run_case("R1 R5 R6 2bpp bus16 BE", 1, 2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h9C, 3, 32'hDEAD_BEEF);
    run_case("R1 R4 R6 4bpp bus8 LE", 2, 1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h70, 4, 32'hCAFE_F00D);
    run_case("R1 R6 4bpp bus4 ratio1", 2, 0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hB0, 6, 32'h7777_ABCD);
    run_case("R1 R6 2bpp bus4 BE", 1, 0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h33, 3, 32'h0000_FFF6);
    run_case("R2 R4 8bpp bus32 LE page00", 3, 3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 3, 32'h0102_0304);
    run_case("R2 R5 8bpp bus32 BE pageFF", 3, 3, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 3, 32'h0102_0304);
    run_case("R2 R6 8bpp bus16 pageFF", 3, 2, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 3, 32'h8899_1122);
    run_case("R7 nibble low", 3, 0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hE5, 3, 32'hA1B2_C3D4);
    run_case("R7 nibble high BE", 0, 3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h2F, 3, 32'hA1B2_C3D4);
    run_case("R8 nibble inhibited", 3, 3, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 2, 32'h5566_7788);
    test_r9_error();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule